// File: doc/BRIEF.md
# Per-Channel Streaming Tap with Register Window Forwarding

This block sits in one direction of the byte-wide synchronous data path of a ring network interface. Every byte on the path carries a logical channel tag. For a small group of stream-capable channels, a per-channel mode decides what happens to the byte. It can go through untouched (pass). It can be handed to an external streaming module and blanked on the path (sink). It can be replaced by a byte the external module supplies (source). Or it can be handed out while the external module's processed byte takes its place (preprocess). All of this happens in real time. The path never stalls, and it always delivers its result one cycle after the input slot.

The block also watches host register requests. Requests whose address falls inside one fixed window are forwarded to the external module, so that module can expose its own control registers through the host map. A forwarded read waits for the module's answer. If no answer comes within a bounded number of cycles, the host gets a marker word and an error indication.

Top module: `strm_tap`

## Requirements
- R1: `out_vld` and `out_ch` repeat `in_vld` and `in_ch` exactly one cycle later, for every slot, whatever the channel's mode.
- R2: Mode code 0 (pass): `out_byte` equals the input byte of the slot. `eg_vld` and `ig_rdy` stay low for that slot.
- R3: Mode code 1 (sink): the byte and its channel appear on `eg_byte`/`eg_ch` with `eg_vld` high one cycle after the slot. The path output of that slot carries 0x00.
- R4: Mode code 2 (source): `ig_rdy` is high in the slot's own cycle. The ingress byte offered in that cycle becomes `out_byte` one cycle later. Nothing is sent on egress.
- R5: Mode code 3 (preprocess): the slot's byte is sent on egress as in R3, and the path output is the ingress byte as in R4.
- R6: When `ig_rdy` is high and `ig_vld` is low, the output byte of that slot is 0x00 and `out_und` is high for exactly that output cycle.
- R7: Only channels 1 to 4 (parameter `STRM_LO` and `STRM_N`) obey their 2-bit mode at `mode_cfg[2*ch+1:2*ch]`. Every other channel behaves as pass whatever its configured code.
- R8: An egress byte is offered for one cycle only. If `eg_rdy` is low in that cycle, the byte is lost and `eg_drop` is high in that same cycle.
- R9: A host request accepted while `host_rdy` is high, with `hreq_addr[11:6]` equal to 0x0F (window 0x3C0 to 0x3FF), is driven on `xreq_*` one cycle later, carrying address bits [5:0], the write flag and the write data. A request outside the window produces no forward and no response.
- R10: A forwarded write is answered by the block in the same cycle as the forward: `hrsp_vld` high, `hrsp_rdata` 0, `hrsp_err` 0.
- R11: A forwarded read drops `host_rdy` from the forward cycle on. When `xrsp_vld` is high in wait cycle k (the forward cycle is wait cycle 1, k up to 16), `hrsp_vld` with `xrsp_rdata` follows in cycle k+1.
- R12: If no `xrsp_vld` arrives in wait cycles 1 to 16, the block answers in cycle 17 with `hrsp_rdata` 0xDEADBEEF and `hrsp_err` high, and `host_rdy` returns high.
- R13: While a read waits, new host requests are ignored. An `xrsp_vld` that arrives when no read is waiting is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 2*2^CH_W | Two mode bits per channel |
| in_vld | input | 1 | Input slot valid |
| in_byte | input | 8 | Input slot byte |
| in_ch | input | CH_W | Input slot channel |
| out_vld | output | 1 | Output slot valid |
| out_byte | output | 8 | Output slot byte |
| out_ch | output | CH_W | Output slot channel |
| out_und | output | 1 | Ingress underrun on this output slot |
| eg_vld | output | 1 | Egress byte valid |
| eg_byte | output | 8 | Egress byte |
| eg_ch | output | CH_W | Egress channel tag |
| eg_rdy | input | 1 | External module accepts egress byte |
| eg_drop | output | 1 | Egress byte lost this cycle |
| ig_vld | input | 1 | Ingress byte valid |
| ig_byte | input | 8 | Ingress byte |
| ig_rdy | output | 1 | Ingress byte taken this cycle |
| hreq_vld | input | 1 | Host request valid |
| hreq_wr | input | 1 | Host request is a write |
| hreq_addr | input | AW | Host request address |
| hreq_wdata | input | 32 | Host write data |
| host_rdy | output | 1 | Block can take a host request |
| hrsp_vld | output | 1 | Host response valid |
| hrsp_rdata | output | 32 | Host response data |
| hrsp_err | output | 1 | Host response timed out |
| xreq_vld | output | 1 | Forwarded request valid |
| xreq_wr | output | 1 | Forwarded request is a write |
| xreq_addr | output | WIN_AW | Offset inside the window |
| xreq_wdata | output | 32 | Forwarded write data |
| xrsp_vld | input | 1 | External read response valid |
| xrsp_rdata | input | 32 | External read response data |

## Verification
Path results and egress offers are due one cycle after the input slot. `ig_rdy` and `eg_drop` are due in the same cycle as the signals they follow. Forwards and write acknowledgements arrive one cycle after acceptance, and read answers arrive one cycle after the sampled response, or in the 17th cycle on timeout. A behavioural model in the bench advances on each rising edge from the inputs held stable since the previous falling edge. The outputs are compared with it one nanosecond after each falling edge, once the new inputs have settled. As a result, registered results are always compared in the cycle after their cause, and combinational ones in the cycle of their cause. Directed host sequences hit the first and last allowed response cycles, the timeout, a late response, requests during a wait and addresses just outside the window.

// File: rtl/strm_tap.sv
module strm_tap #(
  parameter int CH_W = 4,
  parameter int STRM_LO = 1,
  parameter int STRM_N = 4,
  parameter int AW = 12,
  parameter int WIN_AW = 6,
  parameter logic [AW-1:0] WIN_BASE = 12'h3C0,
  parameter int TMO = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*(1<<CH_W)-1:0]   mode_cfg,
  input  logic                     in_vld,
  input  logic [7:0]               in_byte,
  input  logic [CH_W-1:0]          in_ch,
  output logic                     out_vld,
  output logic [7:0]               out_byte,
  output logic [CH_W-1:0]          out_ch,
  output logic                     out_und,
  output logic                     eg_vld,
  output logic [7:0]               eg_byte,
  output logic [CH_W-1:0]          eg_ch,
  input  logic                     eg_rdy,
  output logic                     eg_drop,
  input  logic                     ig_vld,
  input  logic [7:0]               ig_byte,
  output logic                     ig_rdy,
  input  logic                     hreq_vld,
  input  logic                     hreq_wr,
  input  logic [AW-1:0]            hreq_addr,
  input  logic [31:0]              hreq_wdata,
  output logic                     host_rdy,
  output logic                     hrsp_vld,
  output logic [31:0]              hrsp_rdata,
  output logic                     hrsp_err,
  output logic                     xreq_vld,
  output logic                     xreq_wr,
  output logic [WIN_AW-1:0]        xreq_addr,
  output logic [31:0]              xreq_wdata,
  input  logic                     xrsp_vld,
  input  logic [31:0]              xrsp_rdata
);
  localparam logic [CH_W:0] LO_V = (CH_W+1)'(STRM_LO);
  localparam logic [CH_W:0] HI_V = (CH_W+1)'(STRM_LO + STRM_N);
  localparam int TW = $clog2(TMO);
  localparam logic [TW-1:0] CNT_LAST = TW'(TMO - 1);

  typedef enum logic [1:0] {M_PASS = 2'd0, M_SINK = 2'd1, M_SRC = 2'd2, M_PRE = 2'd3} mode_e;

  mode_e      m;
  logic       strm_ok, take, send;
  logic [1:0] cfg_m;

  assign cfg_m   = mode_cfg[{in_ch, 1'b0} +: 2];
  assign strm_ok = ({1'b0, in_ch} >= LO_V) && ({1'b0, in_ch} < HI_V);
  assign m       = strm_ok ? mode_e'(cfg_m) : M_PASS;
  assign take    = in_vld && (m == M_SRC || m == M_PRE);
  assign send    = in_vld && (m == M_SINK || m == M_PRE);
  assign ig_rdy  = take;
  assign eg_drop = eg_vld & ~eg_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_byte <= '0;
      out_ch   <= '0;
      out_und  <= 1'b0;
      eg_vld   <= 1'b0;
      eg_byte  <= '0;
      eg_ch    <= '0;
    end else begin
      out_vld <= in_vld;
      out_ch  <= in_ch;
      out_und <= take & ~ig_vld;
      if (!in_vld || m == M_SINK) out_byte <= '0;
      else if (m == M_PASS)       out_byte <= in_byte;
      else                        out_byte <= ig_vld ? ig_byte : 8'h00;
      eg_vld  <= send;
      eg_byte <= send ? in_byte : 8'h00;
      eg_ch   <= send ? in_ch : '0;
    end
  end

  logic          busy, in_win, accept;
  logic [TW-1:0] cnt;

  assign in_win   = hreq_addr[AW-1:WIN_AW] == WIN_BASE[AW-1:WIN_AW];
  assign host_rdy = ~busy;
  assign accept   = hreq_vld & ~busy & in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      xreq_vld   <= 1'b0;
      xreq_wr    <= 1'b0;
      xreq_addr  <= '0;
      xreq_wdata <= '0;
      hrsp_vld   <= 1'b0;
      hrsp_rdata <= '0;
      hrsp_err   <= 1'b0;
    end else begin
      xreq_vld   <= accept;
      hrsp_vld   <= 1'b0;
      hrsp_rdata <= '0;
      hrsp_err   <= 1'b0;
      if (accept) begin
        xreq_wr    <= hreq_wr;
        xreq_addr  <= hreq_addr[WIN_AW-1:0];
        xreq_wdata <= hreq_wdata;
        if (hreq_wr) hrsp_vld <= 1'b1;
        else begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end
      if (busy) begin
        if (xrsp_vld) begin
          hrsp_vld   <= 1'b1;
          hrsp_rdata <= xrsp_rdata;
          busy       <= 1'b0;
        end else if (cnt == CNT_LAST) begin
          hrsp_vld   <= 1'b1;
          hrsp_rdata <= 32'hDEADBEEF;
          hrsp_err   <= 1'b1;
          busy       <= 1'b0;
        end else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strm_tap_chk.sv
module strm_tap_chk #(
  parameter int CH_W = 4,
  parameter int TMO = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [CH_W-1:0] in_ch,
  input logic            out_vld,
  input logic [7:0]      out_byte,
  input logic [CH_W-1:0] out_ch,
  input logic            out_und,
  input logic            eg_vld,
  input logic            eg_drop,
  input logic            ig_rdy,
  input logic            host_rdy,
  input logic            hrsp_vld,
  input logic [31:0]     hrsp_rdata,
  input logic            hrsp_err,
  input logic            xreq_vld,
  input logic            xreq_wr
);
  int unsigned wait_len;
  always_ff @(posedge clk) begin
    if (!rst_n || host_rdy) wait_len <= 0;
    else wait_len <= wait_len + 1;
  end

  a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld);
  a_r1_ch_follows:  assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_ch == $past(in_ch));
  a_r4_rdy_in_slot: assert property (@(posedge clk) disable iff (!rst_n) ig_rdy |-> in_vld);
  a_r6_und_zero:    assert property (@(posedge clk) disable iff (!rst_n) out_und |-> (out_vld && out_byte == 8'h00));
  a_r8_drop_offer:  assert property (@(posedge clk) disable iff (!rst_n) eg_drop |-> eg_vld);
  a_r11_rd_busy:    assert property (@(posedge clk) disable iff (!rst_n) (xreq_vld && !xreq_wr) |-> !host_rdy);
  a_r12_err_word:   assert property (@(posedge clk) disable iff (!rst_n) hrsp_err |-> (hrsp_vld && hrsp_rdata == 32'hDEADBEEF));
  a_r12_wait_bound: assert property (@(posedge clk) disable iff (!rst_n) !host_rdy |-> wait_len < TMO);
endmodule

bind strm_tap strm_tap_chk #(.CH_W(CH_W), .TMO(TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch),
  .out_vld(out_vld), .out_byte(out_byte), .out_ch(out_ch), .out_und(out_und),
  .eg_vld(eg_vld), .eg_drop(eg_drop), .ig_rdy(ig_rdy), .host_rdy(host_rdy),
  .hrsp_vld(hrsp_vld), .hrsp_rdata(hrsp_rdata), .hrsp_err(hrsp_err),
  .xreq_vld(xreq_vld), .xreq_wr(xreq_wr)
);

// File: tb/strm_tap_tb.sv
module strm_tap_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [31:0] mode_cfg;
  logic in_vld = 0, eg_rdy = 0, ig_vld = 0, hreq_vld = 0, hreq_wr = 0, xrsp_vld = 0;
  logic [7:0] in_byte = 0, ig_byte = 0;
  logic [3:0] in_ch = 0;
  logic [11:0] hreq_addr = 0;
  logic [31:0] hreq_wdata = 0, xrsp_rdata = 0;
  logic out_vld, out_und, eg_vld, eg_drop, ig_rdy, host_rdy, hrsp_vld, hrsp_err, xreq_vld, xreq_wr;
  logic [7:0] out_byte, eg_byte;
  logic [3:0] out_ch, eg_ch;
  logic [31:0] hrsp_rdata, xreq_wdata;
  logic [5:0] xreq_addr;

  strm_tap dut_i (.*);

  int checks = 0, fails = 0, cfgm[16];
  bit run = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bmode(input int ch);
    return (ch >= 1 && ch <= 4) ? cfgm[ch] : 0;
  endfunction

  bit e_vld, e_und, e_egv, e_xv, e_xwr, e_hv, e_herr, mb;
  logic [7:0] e_byte, e_egb;
  logic [3:0] e_ch, e_egc;
  logic [5:0] e_xa;
  logic [31:0] e_xd, e_hd;
  string e_tag, e_htag;
  int mw;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_vld = 0; e_und = 0; e_egv = 0; e_xv = 0; e_hv = 0; e_herr = 0; mb = 0; mw = 0;
      e_byte = 0; e_ch = 0; e_egb = 0; e_egc = 0; e_tag = "R1"; e_htag = "R9";
    end else begin
      int m;
      m = bmode(int'(in_ch));
      e_vld = in_vld; e_ch = in_ch; e_und = 0;
      e_tag = (m == 0) ? ((cfgm[in_ch] != 0) ? "R7" : "R2") : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
      if (m == 0) e_byte = in_byte;
      else if (m == 1) e_byte = 0;
      else begin
        e_byte = ig_vld ? ig_byte : 8'h00;
        e_und = in_vld && !ig_vld;
        if (e_und) e_tag = "R6";
      end
      e_egv = in_vld && (m == 1 || m == 3);
      e_egb = in_byte; e_egc = in_ch;
      e_xv = 0; e_hv = 0; e_herr = 0; e_hd = 0;
      if (mb) begin
        if (xrsp_vld) begin e_hv = 1; e_hd = xrsp_rdata; mb = 0; e_htag = "R11"; end
        else if (mw == 16) begin e_hv = 1; e_hd = 32'hDEADBEEF; e_herr = 1; mb = 0; e_htag = "R12"; end
        else mw++;
      end else if (hreq_vld && hreq_addr[11:6] == 6'h0F) begin
        e_xv = 1; e_xwr = hreq_wr; e_xa = hreq_addr[5:0]; e_xd = hreq_wdata;
        if (hreq_wr) begin e_hv = 1; e_htag = "R10"; end
        else begin mb = 1; mw = 1; end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && run) begin
      int m;
      m = bmode(int'(in_ch));
      chk(out_vld == e_vld, "R1 out_vld", 32'(out_vld), 32'(e_vld));
      if (e_vld) begin
        chk(out_ch == e_ch, "R1 out_ch", 32'(out_ch), 32'(e_ch));
        chk(out_byte == e_byte, e_tag, 32'(out_byte), 32'(e_byte));
      end
      chk(out_und == e_und, "R6 out_und", 32'(out_und), 32'(e_und));
      chk(eg_vld == e_egv, "R3 eg_vld", 32'(eg_vld), 32'(e_egv));
      if (e_egv) begin
        chk(eg_byte == e_egb, "R5 eg_byte", 32'(eg_byte), 32'(e_egb));
        chk(eg_ch == e_egc, "R3 eg_ch", 32'(eg_ch), 32'(e_egc));
      end
      chk(eg_drop == (e_egv && !eg_rdy), "R8 eg_drop", 32'(eg_drop), 32'(e_egv && !eg_rdy));
      chk(ig_rdy == (in_vld && m >= 2), "R4 ig_rdy", 32'(ig_rdy), 32'(in_vld && m >= 2));
      chk(xreq_vld == e_xv, "R9 xreq_vld", 32'(xreq_vld), 32'(e_xv));
      if (e_xv) begin
        chk(xreq_wr == e_xwr, "R9 xreq_wr", 32'(xreq_wr), 32'(e_xwr));
        chk(xreq_addr == e_xa, "R9 xreq_addr", 32'(xreq_addr), 32'(e_xa));
        chk(xreq_wdata == e_xd, "R9 xreq_wdata", xreq_wdata, e_xd);
      end
      chk(host_rdy == !mb, "R13 host_rdy", 32'(host_rdy), 32'(!mb));
      chk(hrsp_vld == e_hv, {e_htag, " hrsp_vld"}, 32'(hrsp_vld), 32'(e_hv));
      if (e_hv) begin
        chk(hrsp_rdata == e_hd, {e_htag, " hrsp_rdata"}, hrsp_rdata, e_hd);
        chk(hrsp_err == e_herr, "R12 hrsp_err", 32'(hrsp_err), 32'(e_herr));
      end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      in_vld  <= ($urandom % 8) != 0;
      in_ch   <= 4'($urandom % 8);
      in_byte <= 8'($urandom);
      ig_vld  <= ($urandom % 5) != 0;
      ig_byte <= 8'($urandom);
      eg_rdy  <= ($urandom % 4) != 0;
    end else begin
      in_vld <= 0; ig_vld <= 0; eg_rdy <= 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hreq(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hreq_vld = 1; hreq_wr = wr; hreq_addr = a; hreq_wdata = d;
    @(negedge clk);
    hreq_vld = 0; hreq_wr = 0;
  endtask

  task automatic xrsp(input logic [31:0] d);
    xrsp_vld = 1; xrsp_rdata = d;
    @(negedge clk);
    xrsp_vld = 0;
  endtask

  task automatic hread(input logic [11:0] a, input int dly, input logic [31:0] d);
    hreq(0, a, d);
    repeat (dly - 1) @(negedge clk);
    xrsp(d);
  endtask

  initial begin
    cfgm = '{3, 0, 1, 2, 3, 3, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0};
    for (int i = 0; i < 16; i++) mode_cfg[2*i +: 2] = 2'(cfgm[i]);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_vld == 0 && eg_vld == 0 && out_und == 0, "R1 reset path", {out_vld, eg_vld, out_und}, 0);
    chk(host_rdy == 1 && hrsp_vld == 0 && xreq_vld == 0, "R11 reset host", {host_rdy, hrsp_vld, xreq_vld}, 4);
    run = 1;
    idle(40);
    hreq(1, 12'h3C5, 32'h11223344);
    idle(3);
    hread(12'h3FF, 3, 32'hCAFE0001);
    idle(3);
    hread(12'h3C0, 1, 32'hCAFE0002);
    idle(3);
    hread(12'h3C2, 16, 32'hCAFE0003);
    idle(3);
    hread(12'h3C3, 20, 32'hCAFE0004);
    idle(3);
    hreq(1, 12'h100, 32'h55);
    hreq(0, 12'h3BF, 32'h0);
    hreq(0, 12'h400, 32'h0);
    idle(3);
    hreq(0, 12'h3C8, 0);
    hreq(1, 12'h3C9, 32'h77);
    idle(2);
    xrsp(32'hCAFE0005);
    idle(3);
    xrsp(32'hBAD0BAD0);
    idle(3);
    for (int k = 0; k < 6; k++) begin
      hread(12'h3C0 + 12'(k), 2 + k * 3, 32'h1000 + 32'(k));
      idle(2);
    end
    idle(200);
    run = 0;
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule